// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns one PWM reference into two complementary pin drives, a main output and a complementary output. When the reference goes active, the complementary output is released at once. The main output is asserted only after a programmable dead time has passed. A falling reference is handled the same way with the roles swapped, so the two power switches are never on together.

The dead time comes from an 8-bit nonlinear code with four ranges. The steps are 1, 2, 8 and 16 dead-time ticks, which gives fine resolution for short gaps and still reaches long ones. A dead-time tick is one, two or four timer cycles.

Each pin has its own polarity bit and its own idle level. An output enable register gates both pins. It is set and cleared by pulses. A break input with a selectable active level and its own enable forces both pins to their idle levels without waiting for a clock edge. A break also clears the output enable and raises a sticky flag. If automatic re-enable is selected, the first update pulse after the break is released turns the outputs back on.

All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake applies.

Top module: `cpwm_deadtime`

## Requirements
- R1: After reset, the output enable is cleared and the break flag is 0. Both pins sit at their idle levels and stay there, whatever the reference does, until an enable pulse arrives.
- R2: With code bit 7 at 0, the dead time is code[6:0] ticks.
- R3: With code[7:6] = 2'b10, the dead time is (64 + code[5:0]) * 2 ticks.
- R4: With code[7:5] = 3'b110, the dead time is (32 + code[4:0]) * 8 ticks.
- R5: With code[7:5] = 3'b111, the dead time is (32 + code[4:0]) * 16 ticks.
- R6: The division select sets the cycles per tick: 2'b00 gives 1 timer cycle, 2'b01 gives 2 and 2'b10 gives 4. The value 2'b11 behaves like 2'b10.
- R7: Let E0 be the first clock edge that samples the reference high, and D the dead time in timer cycles. The complementary output goes inactive after E0 and the main output goes active after edge E0+D. A falling reference does the same with the two outputs swapped. The two outputs are never active together.
- R8: If the reference is sampled high on D or fewer consecutive edges, the main output never goes active. At D+1 edges it does. The same holds for a low pulse and the complementary output.
- R9: While the outputs are enabled, each pin equals its active state XOR its polarity bit. A polarity bit of 0 means active high.
- R10: A break is active when the break enable is 1 and the break input equals the break polarity bit. While it is active, both pins are at their idle levels with no clock edge needed. At the next edge the output enable clears and the flag sets. With the break enable at 0, the break input has no effect.
- R11: After the break is released, an update pulse sets the output enable only when automatic re-enable is 1. A break in the same cycle as the update wins.
- R12: A set pulse sets the output enable and a clear pulse clears it. If both arrive in the same cycle, clear wins. Any re-enable, whether by pulse or automatic, clears the break flag. While the enable is clear, both pins are at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | PWM reference, 1 = main phase |
| dt_code_i | input | 8 | Nonlinear dead-time code |
| dt_div_i | input | 2 | Timer cycles per dead-time tick select |
| main_pol_i | input | 1 | Main pin polarity, 0 = active high |
| comp_pol_i | input | 1 | Complementary pin polarity, 0 = active high |
| main_idle_i | input | 1 | Main pin level when gated off |
| comp_idle_i | input | 1 | Complementary pin level when gated off |
| oe_set_i | input | 1 | Pulse that sets the output enable |
| oe_clr_i | input | 1 | Pulse that clears the output enable |
| brk_en_i | input | 1 | Break detection enable |
| brk_pol_i | input | 1 | Level of brk_i that means break |
| brk_i | input | 1 | Break input |
| auto_oe_i | input | 1 | Re-enable outputs on update after break |
| upd_i | input | 1 | Update event pulse |
| main_o | output | 1 | Main pin |
| comp_o | output | 1 | Complementary pin |
| brk_flag_o | output | 1 | Sticky break flag |

## Verification
The cycle of interest is one where a break and an automatic re-enable by update land on the same edge. The bench asserts the break input and an update pulse together while automatic re-enable is selected. It then releases the break. It expects the pins to stay at their idle levels and the flag to stay set, because the break must win. A second collision, a set pulse and a clear pulse in one cycle, is judged the same way: the pins must stay idle afterwards.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned DT_CODE_W     = 8;
  localparam int unsigned DT_TICK_W     = 10;
  localparam int unsigned DIV_SHIFT_MAX = 2;
  localparam int unsigned DT_CYC_W      = DT_TICK_W + DIV_SHIFT_MAX;
  localparam int unsigned N_CHAN        = 2;

  typedef enum logic [1:0] {
    DIV_BY1  = 2'b00,
    DIV_BY2  = 2'b01,
    DIV_BY4  = 2'b10,
    DIV_RSVD = 2'b11
  } dt_div_e;
endpackage

// File: rtl/cpwm_dt_decode.sv
module cpwm_dt_decode
  import cpwm_pkg::*;
(
  input  logic [DT_CODE_W-1:0] code_i,
  input  logic [1:0]           div_i,
  output logic [DT_CYC_W-1:0]  cycles_o
);
  logic [DT_TICK_W-1:0] ticks;
  logic [1:0]           shift;

  // Piecewise range select on the top code bits.
  always_comb begin
    if (!code_i[7])
      ticks = DT_TICK_W'(code_i[6:0]);
    else if (!code_i[6])
      ticks = DT_TICK_W'({1'b1, code_i[5:0], 1'b0});
    else if (!code_i[5])
      ticks = DT_TICK_W'({1'b1, code_i[4:0], 3'b000});
    else
      ticks = DT_TICK_W'({1'b1, code_i[4:0], 4'b0000});
  end

  always_comb begin
    case (dt_div_e'(div_i))
      DIV_BY1: shift = 2'd0;
      DIV_BY2: shift = 2'd1;
      default: shift = 2'd2;
    endcase
  end

  assign cycles_o = DT_CYC_W'(ticks) << shift;
endmodule

// File: rtl/cpwm_edge_delay.sv
module cpwm_edge_delay #(
  parameter int unsigned CYC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_i,
  input  logic [CYC_W-1:0] dly_i,
  output logic             act_o
);
  logic             in_q;
  logic [CYC_W-1:0] cnt_q;

  // Output follows the input down at once and up after dly_i edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
      act_o <= 1'b0;
    end else begin
      in_q <= in_i;
      if (!in_i) begin
        act_o <= 1'b0;
        cnt_q <= '0;
      end else if (!in_q) begin
        act_o <= (dly_i == '0);
        cnt_q <= CYC_W'(1);
      end else if (!act_o) begin
        if (cnt_q >= dly_i) act_o <= 1'b1;
        else                cnt_q <= cnt_q + CYC_W'(1);
      end
    end
  end
endmodule

// File: rtl/cpwm_brk_ctrl.sv
module cpwm_brk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_raw_i,
  input  logic brk_en_i,
  input  logic brk_pol_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_i,
  input  logic upd_i,
  output logic brk_now_o,
  output logic oe_o,
  output logic flag_o
);
  assign brk_now_o = brk_en_i & (brk_raw_i == brk_pol_i);

  // Priority: break, then clear, then set or automatic re-enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_o   <= 1'b0;
      flag_o <= 1'b0;
    end else if (brk_now_o) begin
      oe_o   <= 1'b0;
      flag_o <= 1'b1;
    end else if (clr_i) begin
      oe_o <= 1'b0;
    end else if (set_i || (auto_i && upd_i)) begin
      oe_o   <= 1'b1;
      flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_i,
  input  logic [DT_CODE_W-1:0] dt_code_i,
  input  logic [1:0]           dt_div_i,
  input  logic                 main_pol_i,
  input  logic                 comp_pol_i,
  input  logic                 main_idle_i,
  input  logic                 comp_idle_i,
  input  logic                 oe_set_i,
  input  logic                 oe_clr_i,
  input  logic                 brk_en_i,
  input  logic                 brk_pol_i,
  input  logic                 brk_i,
  input  logic                 auto_oe_i,
  input  logic                 upd_i,
  output logic                 main_o,
  output logic                 comp_o,
  output logic                 brk_flag_o
);
  logic [DT_CYC_W-1:0] dly_cyc;
  logic                brk_now;
  logic                oe_q;
  logic                gate;
  logic [N_CHAN-1:0]   act_w;
  logic [N_CHAN-1:0]   pol_w;
  logic [N_CHAN-1:0]   idle_w;
  logic [N_CHAN-1:0]   pin_w;
  logic                act_main;
  logic                act_comp;

  cpwm_dt_decode u_dec (
    .code_i   (dt_code_i),
    .div_i    (dt_div_i),
    .cycles_o (dly_cyc)
  );

  cpwm_brk_ctrl u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk_raw_i (brk_i),
    .brk_en_i  (brk_en_i),
    .brk_pol_i (brk_pol_i),
    .set_i     (oe_set_i),
    .clr_i     (oe_clr_i),
    .auto_i    (auto_oe_i),
    .upd_i     (upd_i),
    .brk_now_o (brk_now),
    .oe_o      (oe_q),
    .flag_o    (brk_flag_o)
  );

  // Combinational gate: a break idles the pins without a clock edge.
  assign gate   = oe_q & ~brk_now;
  assign pol_w  = {comp_pol_i, main_pol_i};
  assign idle_w = {comp_idle_i, main_idle_i};

  // Channel 0 follows the reference, channel 1 its inverse.
  for (genvar g = 0; g < N_CHAN; g++) begin : g_ch
    logic src;
    assign src = (g == 0) ? ref_i : ~ref_i;

    cpwm_edge_delay #(.CYC_W(DT_CYC_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  (src),
      .dly_i (dly_cyc),
      .act_o (act_w[g])
    );

    assign pin_w[g] = gate ? (act_w[g] ^ pol_w[g]) : idle_w[g];
  end

  assign act_main = act_w[0];
  assign act_comp = act_w[1];
  assign main_o   = pin_w[0];
  assign comp_o   = pin_w[1];
endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_i,
  input logic act_main,
  input logic act_comp,
  input logic oe_q,
  input logic brk_en_i,
  input logic brk_pol_i,
  input logic brk_i,
  input logic main_idle_i,
  input logic comp_idle_i,
  input logic main_o,
  input logic comp_o,
  input logic brk_flag_o
);
  logic brk_seen;
  assign brk_seen = brk_en_i && (brk_i == brk_pol_i);

  p_comp_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_i) |=> !act_comp);

  p_main_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_i) |=> !act_main);

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_main && act_comp));

  p_main_needs_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_main |-> $past(ref_i));

  p_break_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_seen |-> (main_o == main_idle_i) && (comp_o == comp_idle_i));

  p_break_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_seen |=> brk_flag_o && !oe_q);

  p_disabled_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (main_o == main_idle_i) && (comp_o == comp_idle_i));
endmodule

bind cpwm_deadtime cpwm_deadtime_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_i       (ref_i),
  .act_main    (act_main),
  .act_comp    (act_comp),
  .oe_q        (oe_q),
  .brk_en_i    (brk_en_i),
  .brk_pol_i   (brk_pol_i),
  .brk_i       (brk_i),
  .main_idle_i (main_idle_i),
  .comp_idle_i (comp_idle_i),
  .main_o      (main_o),
  .comp_o      (comp_o),
  .brk_flag_o  (brk_flag_o)
);

// File: tb/cpwm_deadtime_test.sv
`timescale 1ns/1ps
module cpwm_deadtime_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_i = 1'b0;
  logic [7:0] dt_code_i = 8'h00;
  logic [1:0] dt_div_i = 2'b00;
  logic       main_pol_i = 1'b0, comp_pol_i = 1'b0;
  logic       main_idle_i = 1'b0, comp_idle_i = 1'b1;
  logic       oe_set_i = 1'b0, oe_clr_i = 1'b0;
  logic       brk_en_i = 1'b0, brk_pol_i = 1'b1, brk_i = 1'b0;
  logic       auto_oe_i = 1'b0, upd_i = 1'b0;
  logic       main_o, comp_o, brk_flag_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  cpwm_deadtime uut (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dt_code_i(dt_code_i),
    .dt_div_i(dt_div_i), .main_pol_i(main_pol_i), .comp_pol_i(comp_pol_i),
    .main_idle_i(main_idle_i), .comp_idle_i(comp_idle_i),
    .oe_set_i(oe_set_i), .oe_clr_i(oe_clr_i), .brk_en_i(brk_en_i),
    .brk_pol_i(brk_pol_i), .brk_i(brk_i), .auto_oe_i(auto_oe_i),
    .upd_i(upd_i), .main_o(main_o), .comp_o(comp_o), .brk_flag_o(brk_flag_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Dead time in timer cycles, computed from the requirement text.
  function automatic int exp_dly(input logic [7:0] code, input logic [1:0] div);
    int ticks;
    int mul;
    if (code[7] == 1'b0)           ticks = int'(code[6:0]);
    else if (code[7:6] == 2'b10)   ticks = (64 + int'(code[5:0])) * 2;
    else if (code[7:5] == 3'b110)  ticks = (32 + int'(code[4:0])) * 8;
    else                           ticks = (32 + int'(code[4:0])) * 16;
    mul = (div == 2'b00) ? 1 : (div == 2'b01) ? 2 : 4;
    return ticks * mul;
  endfunction

  function automatic string range_tag(input logic [7:0] code, input logic [1:0] div);
    if (div != 2'b00)              return "R6";
    if (code[7] == 1'b0)           return "R2";
    if (code[7:6] == 2'b10)        return "R3";
    if (code[7:5] == 3'b110)       return "R4";
    return "R5";
  endfunction

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input bit rising, input int limit, output int dly, output bit other_ok);
    @(negedge clk);
    ref_i = rising;
    dly = -1;
    other_ok = 1'b1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (k == 1) other_ok = rising ? (comp_o == 1'b0) : (main_o == 1'b0);
      if ((rising ? main_o : comp_o) == 1'b1) begin
        dly = k - 1;
        break;
      end
    end
  endtask

  task automatic run_pair(input logic [7:0] code, input logic [1:0] div);
    int e, d;
    bit ok;
    string tag;
    e = exp_dly(code, div);
    tag = range_tag(code, div);
    @(negedge clk);
    dt_code_i = code;
    dt_div_i = div;
    ref_i = 1'b0;
    wait_cycles(e + 4);
    measure(1'b1, e + 8, d, ok);
    check(d == e, tag, d, e);
    check(ok, "R7", int'(comp_o), 0);
    measure(1'b0, e + 8, d, ok);
    check(d == e, tag, d, e);
    check(ok, "R7", int'(main_o), 0);
  endtask

  task automatic pulse(input int w, output bit seen);
    seen = 1'b0;
    @(negedge clk);
    ref_i = 1'b1;
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      if (main_o) seen = 1'b1;
    end
    ref_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (main_o) seen = 1'b1;
    end
  endtask

  task automatic pulse_set();
    @(negedge clk); oe_set_i = 1'b1;
    @(negedge clk); oe_set_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'd5113));
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(main_o == 1'b0 && comp_o == 1'b1, "R1", int'({main_o, comp_o}), 1);
    check(brk_flag_o == 1'b0, "R1", int'(brk_flag_o), 0);
    dt_code_i = 8'h02;
    ref_i = 1'b1;
    wait_cycles(10);
    ref_i = 1'b0;
    wait_cycles(10);
    check(main_o == 1'b0 && comp_o == 1'b1, "R1", int'({main_o, comp_o}), 1);

    pulse_set();

    // Directed range corners (R2..R5) and division (R6)
    run_pair(8'h00, 2'b00);
    run_pair(8'h7F, 2'b00);
    run_pair(8'h80, 2'b00);
    run_pair(8'hBF, 2'b00);
    run_pair(8'hC0, 2'b00);
    run_pair(8'hDF, 2'b00);
    run_pair(8'hE0, 2'b00);
    run_pair(8'hFF, 2'b00);
    run_pair(8'h05, 2'b01);
    run_pair(8'h05, 2'b10);
    run_pair(8'h05, 2'b11);
    run_pair(8'hFF, 2'b10);

    // Constrained random codes: long ranges only with no division
    for (int t = 0; t < 10; t++) begin
      logic [7:0] c;
      logic [1:0] dv;
      c = 8'($urandom);
      dv = 2'($urandom % 3);
      if (c >= 8'hC0) dv = 2'b00;
      run_pair(c, dv);
    end

    // R8 short pulses around D = 10
    @(negedge clk);
    dt_code_i = 8'd10;
    dt_div_i = 2'b00;
    wait_cycles(14);
    pulse(10, seen);
    check(!seen, "R8", int'(seen), 0);
    wait_cycles(14);
    pulse(11, seen);
    check(seen, "R8", int'(seen), 1);

    // R9 polarity
    @(negedge clk);
    dt_code_i = 8'h02;
    ref_i = 1'b1;
    main_pol_i = 1'b1;
    comp_pol_i = 1'b1;
    wait_cycles(6);
    check(main_o == 1'b0 && comp_o == 1'b1, "R9", int'({main_o, comp_o}), 1);
    ref_i = 1'b0;
    wait_cycles(6);
    check(main_o == 1'b1 && comp_o == 1'b0, "R9", int'({main_o, comp_o}), 2);
    main_pol_i = 1'b0;
    comp_pol_i = 1'b0;
    ref_i = 1'b1;
    wait_cycles(6);
    check(main_o == 1'b1 && comp_o == 1'b0, "R9", int'({main_o, comp_o}), 2);

    // R10 break forces idle without a clock edge
    brk_en_i = 1'b1;
    brk_pol_i = 1'b1;
    brk_i = 1'b1;
    #1;
    check(main_o == 1'b0 && comp_o == 1'b1, "R10", int'({main_o, comp_o}), 1);
    @(negedge clk);
    check(brk_flag_o == 1'b1, "R10", int'(brk_flag_o), 1);
    brk_i = 1'b0;
    @(negedge clk);
    check(main_o == 1'b0 && comp_o == 1'b1, "R12", int'({main_o, comp_o}), 1);

    // R11 update without automatic re-enable has no effect
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    @(negedge clk);
    check(main_o == 1'b0 && comp_o == 1'b1, "R11", int'({main_o, comp_o}), 1);
    auto_oe_i = 1'b1;
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    check(main_o == 1'b1 && comp_o == 1'b0, "R11", int'({main_o, comp_o}), 2);
    check(brk_flag_o == 1'b0, "R12", int'(brk_flag_o), 0);

    // R11 break and update in one cycle: break wins
    brk_i = 1'b1;
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    brk_i = 1'b0;
    @(negedge clk);
    check(main_o == 1'b0 && comp_o == 1'b1, "R11", int'({main_o, comp_o}), 1);
    check(brk_flag_o == 1'b1, "R11", int'(brk_flag_o), 1);
    auto_oe_i = 1'b0;
    pulse_set();
    @(negedge clk);
    check(main_o == 1'b1, "R12", int'(main_o), 1);

    // R10 low-active break level
    brk_pol_i = 1'b0;
    brk_i = 1'b1;
    @(negedge clk);
    check(main_o == 1'b1, "R10", int'(main_o), 1);
    brk_i = 1'b0;
    #1;
    check(main_o == 1'b0 && comp_o == 1'b1, "R10", int'({main_o, comp_o}), 1);
    @(negedge clk);
    brk_i = 1'b1;
    pulse_set();
    @(negedge clk);

    // R10 break disabled: input ignored
    brk_en_i = 1'b0;
    brk_i = 1'b0;
    wait_cycles(3);
    check(main_o == 1'b1 && comp_o == 1'b0, "R10", int'({main_o, comp_o}), 2);
    check(brk_flag_o == 1'b0, "R10", int'(brk_flag_o), 0);

    // R12 set and clear together: clear wins
    oe_set_i = 1'b1;
    oe_clr_i = 1'b1;
    @(negedge clk);
    oe_set_i = 1'b0;
    oe_clr_i = 1'b0;
    check(main_o == 1'b0 && comp_o == 1'b1, "R12", int'({main_o, comp_o}), 1);
    pulse_set();
    check(main_o == 1'b1, "R12", int'(main_o), 1);
    oe_clr_i = 1'b1;
    @(negedge clk);
    oe_clr_i = 1'b0;
    check(main_o == 1'b0 && comp_o == 1'b1, "R12", int'({main_o, comp_o}), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule